// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block steers one vector operation of length VL under two independent element masks: one for the source vector and one for the destination vector. After a start request it produces, one per cycle, the pair (source element index, destination element index) that the datapath should process next. A zero mask bit means that element is skipped. Each side moves past its own zero bits, so one loop can compress a sparse source into a dense destination, expand a dense source into a sparse destination, or do both at once.

The loop ends as soon as either side has no enabled element left below VL. Any destination elements that were not reached stay unwritten. The running source and destination steps are held in registers and shown on outputs after every pair. When an interrupted loop is restarted, these steps are given back as the starting steps, and mask bits below them are ignored. A parameter chooses between two variants. One skips a whole run of zero bits in a single cycle with a find-first-set. The other steps one element per cycle. Both produce the same pairs.

Top module: `twin_pred_stepper`

## Requirements
- R1: A zero mask bit means the element is skipped. Each emitted pair joins the next enabled source element with the next enabled destination element. Source and destination indices both strictly ascend within one loop.
- R2: With source mask 0b101, destination mask 0b111 and VL=3, the pairs are exactly (0,0) then (2,1).
- R3: With source mask 0b111, destination mask 0b101 and VL=3, the pairs are exactly (0,0) then (1,2).
- R4: With source mask 0b101, destination mask 0b010 and VL=3, exactly one pair (0,1) is produced.
- R5: The loop ends as soon as either step runs out of enabled elements below VL. `done` then pulses for one cycle, with `pair_valid` low, and `busy` is low from that cycle on.
- R6: A loop started with nonzero starting steps ignores mask bits below them. With VL=4, source step 1, destination step 2, source mask 0b0101 and destination mask 0b1010, the only pair is (2,3).
- R7: In every cycle where `pair_valid` is high, `src_step` equals `pair_src`+1 and `dst_step` equals `pair_dst`+1.
- R8: After reset, and in the cycle `done` is high, both step outputs are zero.
- R9: A start with VL=0, or with a starting step at or above VL, gives `done` in the first cycle after the start and emits no pair.
- R10: Mask bits at positions at or above VL have no effect on the pairs.
- R11: A start request while `busy` is high is ignored, and the running loop's pairs are unchanged.
- R12: The find-first-set variant (SKIP_RUNS=1) and the one-element-per-cycle variant (SKIP_RUNS=0) emit identical pair sequences.
- R13: In the find-first-set variant, after a start is accepted at a clock edge, the n pairs appear on the next n edges, one per cycle, and `done` appears on the edge after the last pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted while idle |
| vl | input | CW | Vector length (clamped to MAXVL) |
| src_mask | input | MAXVL | Source element enables, bit i for element i |
| dst_mask | input | MAXVL | Destination element enables, bit i for element i |
| src_step_in | input | CW | Starting source step |
| dst_step_in | input | CW | Starting destination step |
| busy | output | 1 | A loop is running |
| pair_valid | output | 1 | `pair_src`/`pair_dst` carry a pair this cycle |
| pair_src | output | IW | Source element index |
| pair_dst | output | IW | Destination element index |
| done | output | 1 | One-cycle end-of-loop pulse |
| src_step | output | CW | Current source step (save/restore state) |
| dst_step | output | CW | Current destination step (save/restore state) |

## Verification
The bench drives mask patterns that separate the three behaviours: a sparse source only (compress, where the source side runs out first), a sparse destination only (expand, where the destination side runs out first), and two interleaved sparse masks (both sides skipping). A dense eight-element mix exercises long runs of skips. Resumed loops with nonzero steps show whether bits below the step are really ignored. Masks with bits set above VL show whether the search stops at VL. A second instance with the per-element variant runs on the same stimulus, so any difference between skipping a run in one cycle and stepping through it element by element appears as a mismatch in the pair lists.

// File: rtl/twin_step_pkg.sv
package twin_step_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/elem_finder.sv
module elem_finder #(
  parameter int N         = 8,
  parameter int CW        = 4,
  parameter int IW        = 3,
  parameter bit SKIP_RUNS = 1'b1
) (
  input  logic [N-1:0]  mask,
  input  logic [CW-1:0] from,
  input  logic [CW-1:0] limit,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic          exhausted
);
  generate
    if (SKIP_RUNS) begin : g_ffs
      logic [N-1:0] live;
      for (genvar i = 0; i < N; i++) begin : g_win
        assign live[i] = mask[i] && (CW'(i) >= from) && (CW'(i) < limit);
      end
      always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (live[i]) begin
            hit = 1'b1;
            idx = IW'(i);
          end
        end
      end
      assign exhausted = !hit;
    end else begin : g_walk
      logic at_bit;
      always_comb begin
        at_bit = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (from == CW'(i)) at_bit = mask[i];
        end
      end
      assign hit       = (from < limit) && at_bit;
      assign idx       = from[IW-1:0];
      assign exhausted = (from >= limit);
    end
  endgenerate
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import twin_step_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] vl,
  input  logic [N-1:0]  src_mask,
  input  logic [N-1:0]  dst_mask,
  input  logic [CW-1:0] src_step_in,
  input  logic [CW-1:0] dst_step_in,
  input  logic          s_hit,
  input  logic [IW-1:0] s_idx,
  input  logic          s_exh,
  input  logic          d_hit,
  input  logic [IW-1:0] d_idx,
  input  logic          d_exh,
  output logic [N-1:0]  sm_q,
  output logic [N-1:0]  dm_q,
  output logic [CW-1:0] vl_q,
  output logic [CW-1:0] src_step,
  output logic [CW-1:0] dst_step,
  output logic          busy,
  output logic          pair_valid,
  output logic [IW-1:0] pair_src,
  output logic [IW-1:0] pair_dst,
  output logic          done,
  output logic          emit_ev,
  output logic          finish_ev
);
  localparam logic [CW-1:0] VL_MAX = CW'(N);

  seq_state_e state;

  function automatic logic [CW-1:0] next_after(input logic [IW-1:0] i);
    return CW'(i) + CW'(1);
  endfunction

  function automatic logic [CW-1:0] clamp_vl(input logic [CW-1:0] v);
    return (v > VL_MAX) ? VL_MAX : v;
  endfunction

  assign busy      = (state == SEQ_RUN);
  assign finish_ev = busy && (s_exh || d_exh);
  assign emit_ev   = busy && !finish_ev && s_hit && d_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      sm_q       <= '0;
      dm_q       <= '0;
      vl_q       <= '0;
      src_step   <= '0;
      dst_step   <= '0;
      pair_valid <= 1'b0;
      pair_src   <= '0;
      pair_dst   <= '0;
      done       <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      done       <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state    <= SEQ_RUN;
            sm_q     <= src_mask;
            dm_q     <= dst_mask;
            vl_q     <= clamp_vl(vl);
            src_step <= src_step_in;
            dst_step <= dst_step_in;
          end
        end
        default: begin
          if (finish_ev) begin
            state    <= SEQ_IDLE;
            done     <= 1'b1;
            src_step <= '0;
            dst_step <= '0;
          end else if (emit_ev) begin
            pair_valid <= 1'b1;
            pair_src   <= s_idx;
            pair_dst   <= d_idx;
            src_step   <= next_after(s_idx);
            dst_step   <= next_after(d_idx);
          end else begin
            if (!s_hit) src_step <= src_step + CW'(1);
            if (!d_hit) dst_step <= dst_step + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/twin_pred_stepper.sv
module twin_pred_stepper #(
  parameter int MAXVL     = 8,
  parameter bit SKIP_RUNS = 1'b1,
  localparam int CW = $clog2(MAXVL + 1),
  localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic [CW-1:0]    src_step_in,
  input  logic [CW-1:0]    dst_step_in,
  output logic             busy,
  output logic             pair_valid,
  output logic [IW-1:0]    pair_src,
  output logic [IW-1:0]    pair_dst,
  output logic             done,
  output logic [CW-1:0]    src_step,
  output logic [CW-1:0]    dst_step
);
  logic [MAXVL-1:0] sm_q, dm_q;
  logic [CW-1:0]    vl_q;
  logic             s_hit, s_exh, d_hit, d_exh;
  logic [IW-1:0]    s_idx, d_idx;
  logic             emit_ev, finish_ev;

  elem_finder #(.N(MAXVL), .CW(CW), .IW(IW), .SKIP_RUNS(SKIP_RUNS)) u_src_find (
    .mask(sm_q), .from(src_step), .limit(vl_q),
    .hit(s_hit), .idx(s_idx), .exhausted(s_exh)
  );

  elem_finder #(.N(MAXVL), .CW(CW), .IW(IW), .SKIP_RUNS(SKIP_RUNS)) u_dst_find (
    .mask(dm_q), .from(dst_step), .limit(vl_q),
    .hit(d_hit), .idx(d_idx), .exhausted(d_exh)
  );

  step_ctrl #(.N(MAXVL), .CW(CW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_step_in(src_step_in), .dst_step_in(dst_step_in),
    .s_hit(s_hit), .s_idx(s_idx), .s_exh(s_exh),
    .d_hit(d_hit), .d_idx(d_idx), .d_exh(d_exh),
    .sm_q(sm_q), .dm_q(dm_q), .vl_q(vl_q),
    .src_step(src_step), .dst_step(dst_step), .busy(busy),
    .pair_valid(pair_valid), .pair_src(pair_src), .pair_dst(pair_dst),
    .done(done), .emit_ev(emit_ev), .finish_ev(finish_ev)
  );
endmodule

// File: rtl/twin_pred_stepper_chk.sv
module twin_pred_stepper_chk #(
  parameter int CW = 4,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          pair_valid,
  input logic [IW-1:0] pair_src,
  input logic [IW-1:0] pair_dst,
  input logic          done,
  input logic [CW-1:0] src_step,
  input logic [CW-1:0] dst_step,
  input logic          emit_ev,
  input logic          finish_ev
);
  // R1
  ascending_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && $past(pair_valid) |->
      (pair_src > $past(pair_src)) && (pair_dst > $past(pair_dst)));

  // R1
  emit_shows_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_ev |=> pair_valid);

  // R5
  finish_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> done && !busy);

  // R5
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pair_valid && !busy);

  // R7
  step_follows_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (src_step == CW'(pair_src) + CW'(1)) &&
                   (dst_step == CW'(pair_dst) + CW'(1)));

  // R8
  steps_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (src_step == '0) && (dst_step == '0));

  // R13
  output_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid || done) |-> $past(busy));
endmodule

bind twin_pred_stepper twin_pred_stepper_chk #(.CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pair_valid(pair_valid),
  .pair_src(pair_src), .pair_dst(pair_dst), .done(done),
  .src_step(src_step), .dst_step(dst_step),
  .emit_ev(emit_ev), .finish_ev(finish_ev)
);

// File: tb/tb_twin_pred_stepper.sv
`timescale 1ns/1ps
module tb_twin_pred_stepper;
  localparam int MAXVL = 8;
  localparam int CW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic [CW-1:0] src_step_in = '0, dst_step_in = '0;

  logic busy, pair_valid, done;
  logic [IW-1:0] pair_src, pair_dst;
  logic [CW-1:0] src_step, dst_step;
  logic s_busy, s_valid, s_done;
  logic [IW-1:0] s_src, s_dst;
  logic [CW-1:0] s_sstep, s_dstep;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  twin_pred_stepper #(.MAXVL(MAXVL), .SKIP_RUNS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_step_in(src_step_in), .dst_step_in(dst_step_in),
    .busy(busy), .pair_valid(pair_valid), .pair_src(pair_src),
    .pair_dst(pair_dst), .done(done), .src_step(src_step), .dst_step(dst_step)
  );

  twin_pred_stepper #(.MAXVL(MAXVL), .SKIP_RUNS(1'b0)) dut_slow (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_step_in(src_step_in), .dst_step_in(dst_step_in),
    .busy(s_busy), .pair_valid(s_valid), .pair_src(s_src),
    .pair_dst(s_dst), .done(s_done), .src_step(s_sstep), .dst_step(s_dstep)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input int vlv, input logic [7:0] sm,
                     input logic [7:0] dm, input int ss, input int ds,
                     input bit poke);
    int es[16], ed[16], fs[16], fd[16], ws[16], wd[16];
    int n = 0, fn = 0, wn = 0, fdone = 0, wdone = 0;
    int s = ss, d = ds;
    // independent model: walk each mask, pair enabled elements
    while (s < vlv && d < vlv) begin
      if (!sm[s]) s++;
      else if (!dm[d]) d++;
      else begin
        es[n] = s; ed[n] = d; n++; s++; d++;
      end
    end
    @(negedge clk);
    vl = CW'(vlv); src_mask = sm; dst_mask = dm;
    src_step_in = CW'(ss); dst_step_in = CW'(ds);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (fdone == 0) begin
        if (pair_valid && fn < 16) begin
          fs[fn] = int'(pair_src); fd[fn] = int'(pair_dst); fn++;
          check(src_step == CW'(pair_src) + 1 && dst_step == CW'(pair_dst) + 1,
                "R7", "step after pair", int'(src_step), int'(pair_src) + 1);
        end
        if (done) begin
          fdone = c;
          check(src_step == 0 && dst_step == 0, "R8", "steps at done",
                int'(src_step) + int'(dst_step), 0);
        end
      end
      if (wdone == 0) begin
        if (s_valid && wn < 16) begin
          ws[wn] = int'(s_src); wd[wn] = int'(s_dst); wn++;
        end
        if (s_done) wdone = c;
      end
      if (poke && c == 2) begin
        start = 1'b1; vl = '0; src_mask = '0; dst_mask = '0;
      end
      if (poke && c == 3) start = 1'b0;
      if (fdone != 0 && wdone != 0) break;
    end
    start = 1'b0;
    check(fdone != 0, tag, "done seen", fdone, n + 1);
    check(fn == n, tag, "pair count", fn, n);
    for (int i = 0; i < n && i < fn; i++) begin
      check(fs[i] == es[i], tag, $sformatf("pair %0d src", i), fs[i], es[i]);
      check(fd[i] == ed[i], tag, $sformatf("pair %0d dst", i), fd[i], ed[i]);
    end
    check(fdone == n + 1, "R13", {tag, " done latency"}, fdone, n + 1);
    check(!busy, "R5", {tag, " idle after done"}, int'(busy), 0);
    check(wn == fn, "R12", {tag, " variant pair count"}, wn, fn);
    for (int i = 0; i < wn && i < fn; i++) begin
      check(ws[i] == fs[i] && wd[i] == fd[i], "R12", {tag, " variant pair"},
            ws[i] * 16 + wd[i], fs[i] * 16 + fd[i]);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !pair_valid && !done, "R8", "reset outputs quiet",
          int'(busy) + int'(pair_valid) + int'(done), 0);
    check(src_step == 0 && dst_step == 0, "R8", "reset steps",
          int'(src_step) + int'(dst_step), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R2", 3, 8'b101, 8'b111, 0, 0, 1'b0);
    run("R3", 3, 8'b111, 8'b101, 0, 0, 1'b0);
    run("R4", 3, 8'b101, 8'b010, 0, 0, 1'b0);
    run("R6", 4, 8'b0101, 8'b1010, 1, 2, 1'b0);
    run("R1", 8, 8'b1011_0101, 8'b0110_1110, 0, 0, 1'b0);
    run("R1", 3, 8'b100, 8'b010, 0, 0, 1'b0);
    run("R9", 0, 8'hFF, 8'hFF, 0, 0, 1'b0);
    run("R9", 4, 8'hFF, 8'hFF, 5, 0, 1'b0);
    run("R10", 3, 8'hFF, 8'hFF, 0, 0, 1'b0);
    run("R10", 3, 8'b1111_1001, 8'b1111_1010, 0, 0, 1'b0);
    run("R5", 5, 8'b0_0011, 8'b1_1111, 0, 0, 1'b0);
    run("R11", 8, 8'hFF, 8'hFF, 0, 0, 1'b1);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule